// File: doc/BRIEF.md
# Multi-Converter Serial Read Sequencer

This block is the host side of a small acquisition system. Several 14-bit serial converters share one serial clock line and one pulled-up, tri-state data return line. A common convert line starts sampling on all of them together. Each converter has its own active-low select input. On `start` the block raises `cnv` with every select high and waits for the conversion to finish. It then selects the converters one at a time, generates the serial clock and gathers each result MSB first.

Completion is found in one of two ways, chosen per round by `busy_mode`. In timed mode the block waits a fixed worst-case conversion time with all selects high. In indicator mode it lowers the select of converter 0 right after the convert edge and waits for that converter to pull the data line low. If that never happens within the window plus a margin, the round is abandoned with an error flag. Ownership of the data line passes from one converter to the next by raising one select and, after a short gap, lowering the next. There is no shared chip select. Each assembled word appears for one cycle with its channel index, and a done pulse closes the round.

Top module: `adc_read_seq`

## Requirements
- R1: After reset `cnv` is low, every `sel_n` bit is high, `sck` is low, and `word_valid`, `done` and `timeout_err` are low.
- R2: `start` in idle raises `cnv` while every `sel_n` bit is high. `cnv` then stays high until the clock edge that ends the round (last word or timeout).
- R3: In timed mode (`busy_mode`=0), all `sel_n` bits stay high for at least CONV_CYCLES clock cycles after `cnv` rises.
- R4: At most one `sel_n` bit is low at any time. Converters are read in index order 0 to NUM_CONV-1. Each select is raised before the next one is lowered.
- R5: `sck` idles low and pulses only while a select is low. A timed-mode read gives 14 `sck` falling edges. `sdo_in` is sampled at each falling edge, before the converter moves on. The value present when the select drops is the MSB (bit 13).
- R6: In indicator mode (`busy_mode`=1), `sel_n[0]` drops one cycle after `cnv` rises. The block waits for a high-to-low change on `sdo_in` before it clocks anything. Converter 0 then gets 15 falling edges, and the first sample (the low indicator) is discarded. The other converters are read as in R5.
- R7: Each result comes out as a one-cycle `word_valid` pulse. `word_data[13]` holds the first captured bit and `word_data[0]` the last. `word_chan` gives the converter index.
- R8: `done` is a one-cycle pulse. It is asserted together with the `word_valid` of converter NUM_CONV-1, and `cnv` is low in that same cycle.
- R9: In indicator mode, if no `sdo_in` fall arrives within CONV_CYCLES+TIMEOUT_MARGIN cycles, `timeout_err` goes high. In the same cycle `cnv` goes low and all selects are high. No word is produced. `timeout_err` stays high until the next accepted `start` clears it.
- R10: A `start` pulse while a round is in progress has no effect. The round still gives exactly NUM_CONV words and one `done`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion round (taken only in idle) |
| busy_mode | input | 1 | 1 = wait for the data-line indicator, 0 = timed wait |
| sdo_in | input | 1 | Shared serial data from the converters (pulled up) |
| cnv | output | 1 | Common convert line |
| sel_n | output | NUM_CONV | Per-converter active-low select |
| sck | output | 1 | Serial clock, idle low |
| word_data | output | WIDTH | Assembled result, MSB first |
| word_chan | output | CHW | Converter index of `word_data` |
| word_valid | output | 1 | One-cycle strobe for `word_data` / `word_chan` |
| done | output | 1 | One-cycle pulse at the end of a round |
| timeout_err | output | 1 | Indicator wait expired; held until next start |

## Verification
The last converter's word strobe, the done pulse and the fall of `cnv` all come from one clock edge. If they drift apart, a host could see `done` before the final word, or the convert line could drop while a word is still pending. Every round provokes this coincidence, because the final converter always ends it. The bench samples all three in the same half-cycle and checks that the final strobe carries the top channel index, with `done` high and `cnv` low beside it. A second overlap is checked in the same runs: an extra `start` pulse that lands mid-round while `cnv` is already high. The bench judges it by counting exactly NUM_CONV words and one done.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_XFER,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/rdseq_timer.sv
// Down-counter: a load of V gives an expire pulse V edges later; a load of 0 cancels.
module rdseq_timer #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] value,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt <= value;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == TW'(1)) expire <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdseq_shifter.sv
// Serial clock engine: low half, high half, fall; samples the data line at every fall.
module rdseq_shifter #(
  parameter int WIDTH    = 14,
  parameter int SCK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             skip_first,
  input  logic             sdo_in,
  output logic             sck,
  output logic [WIDTH-1:0] word,
  output logic             finish
);
  localparam int HW = $clog2(SCK_HALF + 1);
  localparam int EW = $clog2(WIDTH + 2);

  logic          active;
  logic          skip_q;
  logic [HW-1:0] half_cnt;
  logic [EW-1:0] fall_cnt;
  logic [EW-1:0] last_fall;

  assign last_fall = skip_q ? EW'(WIDTH) : EW'(WIDTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      skip_q   <= 1'b0;
      sck      <= 1'b0;
      half_cnt <= '0;
      fall_cnt <= '0;
      word     <= '0;
      finish   <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (go) begin
        active   <= 1'b1;
        skip_q   <= skip_first;
        sck      <= 1'b0;
        half_cnt <= '0;
        fall_cnt <= '0;
      end else if (active) begin
        if (half_cnt == HW'(SCK_HALF - 1)) begin
          half_cnt <= '0;
          sck      <= ~sck;
          if (sck) begin
            if (!(skip_q && fall_cnt == '0)) word <= {word[WIDTH-2:0], sdo_in};
            fall_cnt <= fall_cnt + 1'b1;
            if (fall_cnt == last_fall) begin
              active <= 1'b0;
              finish <= 1'b1;
            end
          end
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import rdseq_pkg::*;
#(
  parameter int NUM_CONV       = 2,
  parameter int WIDTH          = 14,
  parameter int SCK_HALF       = 2,
  parameter int CONV_CYCLES    = 20,
  parameter int TIMEOUT_MARGIN = 8,
  localparam int CHW = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                busy_mode,
  input  logic                sdo_in,
  output logic                cnv,
  output logic [NUM_CONV-1:0] sel_n,
  output logic                sck,
  output logic [WIDTH-1:0]    word_data,
  output logic [CHW-1:0]      word_chan,
  output logic                word_valid,
  output logic                done,
  output logic                timeout_err
);
  localparam int TW = $clog2(CONV_CYCLES + TIMEOUT_MARGIN + SCK_HALF + 1);
  localparam logic [TW-1:0] T_TIMED = TW'(CONV_CYCLES);
  localparam logic [TW-1:0] T_LIMIT = TW'(CONV_CYCLES + TIMEOUT_MARGIN);
  localparam logic [TW-1:0] T_GAP   = TW'(SCK_HALF);
  localparam logic [NUM_CONV-1:0] SEL0   = NUM_CONV'(1);
  localparam logic [CHW-1:0]      LAST_CH = CHW'(NUM_CONV - 1);

  seq_state_t        st;
  logic              mode_q;
  logic              sdo_q;
  logic [CHW-1:0]    chan;
  logic [CHW-1:0]    nxt_chan;
  logic              sdo_fall;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_exp;
  logic              sh_go;
  logic              sh_skip;
  logic              sh_done;
  logic [WIDTH-1:0]  sh_word;

  assign nxt_chan = chan + 1'b1;
  assign sdo_fall = !sel_n[0] && sdo_q && !sdo_in;

  rdseq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .value(tmr_val), .expire(tmr_exp)
  );

  rdseq_shifter #(.WIDTH(WIDTH), .SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .go(sh_go), .skip_first(sh_skip), .sdo_in(sdo_in),
    .sck(sck), .word(sh_word), .finish(sh_done)
  );

  // Timer and shift-engine commands decided from the current state and events
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_go    = 1'b0;
    sh_skip  = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        tmr_load = 1'b1;
        tmr_val  = busy_mode ? T_LIMIT : T_TIMED;
      end
      ST_CONV: if (mode_q) begin
        if (sdo_fall) begin
          tmr_load = 1'b1;   // value 0 cancels the timeout
          sh_go    = 1'b1;
          sh_skip  = 1'b1;
        end
      end else if (tmr_exp) begin
        sh_go = 1'b1;
      end
      ST_XFER: if (sh_done && chan != LAST_CH) begin
        tmr_load = 1'b1;
        tmr_val  = T_GAP;
      end
      ST_GAP: if (tmr_exp) sh_go = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      mode_q      <= 1'b0;
      sdo_q       <= 1'b1;
      chan        <= '0;
      cnv         <= 1'b0;
      sel_n       <= '1;
      word_data   <= '0;
      word_chan   <= '0;
      word_valid  <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      done       <= 1'b0;
      sdo_q      <= sdo_in;
      case (st)
        ST_IDLE: if (start) begin
          cnv         <= 1'b1;
          timeout_err <= 1'b0;
          mode_q      <= busy_mode;
          chan        <= '0;
          st          <= ST_CONV;
        end
        ST_CONV: if (mode_q) begin
          sel_n <= ~SEL0;
          if (sdo_fall) begin
            st <= ST_XFER;
          end else if (tmr_exp) begin
            timeout_err <= 1'b1;
            cnv         <= 1'b0;
            sel_n       <= '1;
            st          <= ST_IDLE;
          end
        end else if (tmr_exp) begin
          sel_n <= ~SEL0;
          st    <= ST_XFER;
        end
        ST_XFER: if (sh_done) begin
          word_data  <= sh_word;
          word_chan  <= chan;
          word_valid <= 1'b1;
          sel_n      <= '1;
          if (chan == LAST_CH) begin
            cnv  <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_GAP;
          end
        end
        ST_GAP: if (tmr_exp) begin
          chan  <= nxt_chan;
          sel_n <= ~(SEL0 << nxt_chan);
          st    <= ST_XFER;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk #(
  parameter int NUM_CONV = 2,
  localparam int CHW = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                cnv,
  input logic [NUM_CONV-1:0] sel_n,
  input logic                sck,
  input logic [CHW-1:0]      word_chan,
  input logic                word_valid,
  input logic                done,
  input logic                timeout_err
);
  assert_cnv_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv) |-> (&sel_n));

  assert_cnv_held_R2: assert property (@(posedge clk) disable iff (rst)
    !(&sel_n) |-> cnv);

  assert_one_select_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n));

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (&sel_n) |-> !sck);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_chan_range_R7: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (int'(word_chan) < NUM_CONV));

  assert_done_last_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (word_valid && !cnv && word_chan == CHW'(NUM_CONV - 1)));

  assert_err_abort_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (!cnv && (&sel_n) && !word_valid));
endmodule

bind adc_read_seq adc_read_seq_chk #(.NUM_CONV(NUM_CONV)) u_chk (.*);

// File: tb/adc_read_seq_bench.sv
module adc_read_seq_bench;
  localparam int NC = 2;
  localparam int W  = 14;
  localparam int CONV_CYC = 20;
  localparam int MODEL_CONV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy_mode = 1'b0;
  logic sdo;
  logic cnv, sck, word_valid, done, timeout_err;
  logic [NC-1:0] sel_n;
  logic [W-1:0]  word_data;
  logic [0:0]    word_chan;

  always #5 clk = ~clk;

  adc_read_seq #(.NUM_CONV(NC), .WIDTH(W), .SCK_HALF(2), .CONV_CYCLES(CONV_CYC),
                 .TIMEOUT_MARGIN(8)) u_adc_read_seq (
    .clk(clk), .rst(rst), .start(start), .busy_mode(busy_mode), .sdo_in(sdo),
    .cnv(cnv), .sel_n(sel_n), .sck(sck), .word_data(word_data),
    .word_chan(word_chan), .word_valid(word_valid), .done(done),
    .timeout_err(timeout_err)
  );

  // Converter models
  logic [W-1:0] conv_data [NC];
  logic suppress = 1'b0;
  logic [NC-1:0] en_v, val_v;

  for (genvar g = 0; g < NC; g++) begin : g_conv
    logic en = 1'b0, val = 1'b0, ready = 1'b0, brd = 1'b0;
    logic p_cnv = 1'b0, p_sel = 1'b1, p_sck = 1'b0;
    int tmr = 0, k = 0;
    assign en_v[g]  = en;
    assign val_v[g] = val;
    always @(negedge clk) begin
      if (cnv && !p_cnv) begin
        tmr = MODEL_CONV; ready = 1'b0; en = 1'b0; brd = 1'b0;
      end else if (tmr > 0) begin
        tmr = tmr - 1;
        if (tmr == 0) begin
          ready = 1'b1;
          if (!sel_n[g] && !suppress) begin brd = 1'b1; en = 1'b1; val = 1'b0; k = 0; end
        end
      end
      if (!sel_n[g] && p_sel && ready && !brd) begin
        en = 1'b1; val = conv_data[g][W-1]; k = 0;
      end
      if (sel_n[g] && !p_sel) begin en = 1'b0; brd = 1'b0; end
      if (!sck && p_sck && en) begin
        k = k + 1;
        if (brd) begin
          if (k <= W) val = conv_data[g][W-k]; else en = 1'b0;
        end else begin
          if (k < W) val = conv_data[g][W-1-k]; else en = 1'b0;
        end
      end
      p_cnv = cnv; p_sel = sel_n[g]; p_sck = sck;
    end
  end

  assign sdo = (|en_v) ? |(en_v & val_v) : 1'b1;

  // Monitor
  int n_chk = 0, n_fail = 0;
  int nw = 0, ndone = 0, cyc = 0, t_rise = 0, t_sel = -1;
  int contention = 0, bad_rise = 0, sck_idle_bad = 0, done_ok = 0;
  logic [W-1:0] got_data [8];
  int got_chan [8];
  logic m_cnv = 1'b0;
  logic [NC-1:0] m_sel = '1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (word_valid && nw < 8) begin got_data[nw] = word_data; got_chan[nw] = int'(word_chan); end
      if (word_valid) nw = nw + 1;
      if (done) begin
        ndone = ndone + 1;
        if (word_valid && int'(word_chan) == NC-1 && !cnv) done_ok = done_ok + 1;
      end
      if (cnv && !m_cnv) begin
        t_rise = cyc; t_sel = -1;
        if (!(&sel_n)) bad_rise = bad_rise + 1;
      end
      if (!(&sel_n) && (&m_sel) && t_sel < 0) t_sel = cyc - t_rise;
      if ($countones(en_v) > 1) contention = contention + 1;
      if ((&sel_n) && sck) sck_idle_bad = sck_idle_bad + 1;
    end
    m_cnv = cnv; m_sel = sel_n;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_true(input string req, input string what, input bit ok, input int act);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected condition true", req, what, act);
    end
  endtask

  task automatic clear_mon();
    nw = 0; ndone = 0; done_ok = 0; contention = 0; bad_rise = 0; sck_idle_bad = 0;
  endtask

  task automatic run_round(input logic bm, input logic [W-1:0] d0, input logic [W-1:0] d1,
                           input logic sup, input int extra_start_at);
    conv_data[0] = d0; conv_data[1] = d1; suppress = sup;
    clear_mon();
    @(negedge clk); busy_mode = bm; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (i == extra_start_at) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      if (ndone > 0 || timeout_err) break;
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_words(input string tag, input logic [W-1:0] d0, input logic [W-1:0] d1);
    check("R7", {tag, " word count"}, nw, 2);
    check("R5", {tag, " word 0 data MSB first"}, int'(got_data[0]), int'(d0));
    check("R4", {tag, " word 0 channel"}, got_chan[0], 0);
    check("R5", {tag, " word 1 data MSB first"}, int'(got_data[1]), int'(d1));
    check("R4", {tag, " word 1 channel"}, got_chan[1], 1);
    check("R8", {tag, " done count"}, ndone, 1);
    check("R8", {tag, " done with last word, cnv low"}, done_ok, 1);
    check("R2", {tag, " cnv low after round"}, int'(cnv), 0);
    check("R2", {tag, " selects high at cnv rise"}, bad_rise, 0);
    check("R4", {tag, " no two selects low"}, contention, 0);
    check("R5", {tag, " sck idle while deselected"}, sck_idle_bad, 0);
  endtask

  task automatic t_reset();
    check("R1", "cnv after reset", int'(cnv), 0);
    check("R1", "sel_n after reset", int'(sel_n), 3);
    check("R1", "sck after reset", int'(sck), 0);
    check("R1", "word_valid after reset", int'(word_valid), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "timeout_err after reset", int'(timeout_err), 0);
  endtask

  task automatic t_timed(input logic [W-1:0] d0, input logic [W-1:0] d1);
    run_round(1'b0, d0, d1, 1'b0, -1);
    check_words("timed", d0, d1);
    check_true("R3", "selects high for conversion window", t_sel >= CONV_CYC, t_sel);
  endtask

  task automatic t_busy();
    run_round(1'b1, 14'h2AAA, 14'h1555, 1'b0, -1);
    check_words("indicator", 14'h2AAA, 14'h1555);
    check("R6", "select 0 drops one cycle after cnv", t_sel, 1);
    check("R6", "no error when indicator arrives", int'(timeout_err), 0);
  endtask

  task automatic t_timeout();
    run_round(1'b1, 14'h0F0F, 14'h3030, 1'b1, -1);
    check("R9", "timeout_err raised", int'(timeout_err), 1);
    check("R9", "no word on timeout", nw, 0);
    check("R9", "cnv low after timeout", int'(cnv), 0);
    check("R9", "selects high after timeout", int'(sel_n), 3);
    check("R9", "no done on timeout", ndone, 0);
    repeat (10) @(negedge clk);
    check("R9", "timeout_err held in idle", int'(timeout_err), 1);
    run_round(1'b0, 14'h1234, 14'h0ABC, 1'b0, -1);
    check("R9", "timeout_err cleared by next start", int'(timeout_err), 0);
    check_words("after timeout", 14'h1234, 14'h0ABC);
  endtask

  task automatic t_overlap();
    run_round(1'b0, 14'h3C3C, 14'h03C3, 1'b0, 40);
    check("R10", "start mid-round: word count", nw, 2);
    check("R10", "start mid-round: done count", ndone, 1);
    check("R10", "start mid-round: data ch0", int'(got_data[0]), int'(14'h3C3C));
    repeat (40) @(negedge clk);
    check("R10", "no new round after stray start", int'(cnv), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timed(14'h2A5C, 14'h1337);
    t_timed(14'h3FFF, 14'h0001);
    t_timed(14'h0000, 14'h2000);
    t_busy();
    t_timeout();
    t_overlap();
    summary();
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected run to complete");
    summary();
    $finish;
  end
endmodule